// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block records, for each of the 16 software-generated interrupts and each target CPU, which source CPUs have asked for that interrupt. Every (CPU, interrupt) pair holds an 8-bit source bitmap and a pending flag. The pending flags go out on a flat vector that the CPU-side delivery logic watches. Software changes the bitmaps through two byte-wide windows. A write to the set window ORs the data byte into the writing CPU's bitmap and forces that interrupt pending. A write to the clear window removes the bits that are 1 in the data byte. The pending flag falls only once the bitmap is empty.

An access from a non-secure agent is honoured only when the interrupt is marked group 1 for the writing CPU. Otherwise the access is silently dropped. A separate acknowledge port lets a CPU interface retire one requester at a time. It sees the lowest set source index in the same cycle and removes that source on the clock edge. A reserved byte range below the two windows reports a bad access. When the block is built in its legacy configuration, both windows also report a bad access.

Top module: `sgi_src_tracker`

## Requirements
- R1: A byte write to address 0xF20 + n (n = 0..15) by CPU c ORs `wr_data` into the bitmap of interrupt n for CPU c. It sets `pend[c*16+n]`, even when the data byte is zero, and the output changes in the cycle after the write edge.
- R2: A byte write to 0xF10 + n by CPU c clears the bitmap bits of (c, n) that are 1 in `wr_data`. `pend[c*16+n]` drops one cycle later if the bitmap is then empty, and it stays set otherwise.
- R3: With the security option enabled, a set or clear write that has `wr_secure` = 0 and `grp1[c*16+n]` = 0 changes no bitmap and no pending bit, and it raises no bad-access report.
- R4: While `ack_en` is high, `ack_valid` is 1 exactly when the bitmap of (`ack_cpu`, `ack_id`) is non-empty. `ack_src` then gives the lowest set bit index, and at the clock edge that bit is cleared.
- R5: An acknowledge that leaves the bitmap empty clears the pending bit one cycle later. An acknowledge on an empty bitmap gives `ack_valid` = 0 and `ack_src` = 0, and it also clears the pending bit.
- R6: When a set write and an acknowledge hit the same (CPU, interrupt) in one cycle, the acknowledge's bit removal is applied first and the set's OR second, and the pending bit remains 1.
- R7: A byte write to 0xF00..0xF0F raises `wr_bad` for exactly the following cycle and changes no state.
- R8: With the legacy option set, writes to 0xF10..0xF2F raise `wr_bad` in the following cycle and change no state.
- R9: Reset clears every bitmap, every pending bit and `wr_bad`.
- R10: A write or acknowledge changes only the entry of the addressed CPU and interrupt. All other pending bits hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 8 | Write data, one bit per source CPU |
| wr_cpu | input | 2 | Index of the writing CPU |
| wr_secure | input | 1 | Write carries the secure attribute |
| grp1 | input | 64 | Group-1 flag per interrupt per CPU, bit c*16+n |
| ack_en | input | 1 | Acknowledge strobe |
| ack_cpu | input | 2 | CPU performing the acknowledge |
| ack_id | input | 4 | Interrupt being acknowledged |
| ack_src | output | 3 | Lowest requesting source index, 0 when none |
| ack_valid | output | 1 | The acknowledged bitmap held at least one source |
| pend | output | 64 | Pending bit per interrupt per CPU, bit c*16+n |
| wr_bad | output | 1 | One-cycle report of an invalid write, one cycle after it |

## Verification
The assertions assume that `wr_cpu` and `ack_cpu` always name an existing CPU and that `grp1` stays steady around a gated write. They also assume that inputs change away from the rising edge. The stimulus changes every input on the falling edge, uses only CPU indices 0 to 3 and loads `grp1` once before the first write. Set and clear writes never reach one entry in the same cycle, because the address decode makes them exclusive. Only the pairing of a write with an acknowledge is driven on purpose.

// File: rtl/sgi_trk_pkg.sv
package sgi_trk_pkg;
  // Which register window a byte address falls into
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_BAD  = 2'd1,
    WIN_CLR  = 2'd2,
    WIN_SET  = 2'd3
  } win_e;
endpackage

// File: rtl/sgi_trk_decode.sv
module sgi_trk_decode
  import sgi_trk_pkg::*;
#(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_SGI   = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [11:0] BASE_ADDR = 12'hF00,
  parameter bit          HAS_SEC   = 1'b1,
  parameter bit          LEGACY    = 1'b0,
  parameter int unsigned CPU_W     = 2,
  parameter int unsigned ID_W      = 4
) (
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CPU_W-1:0]         wr_cpu,
  input  logic                     wr_secure,
  input  logic [NUM_CPU*NUM_SGI-1:0] grp1,
  output win_e                     win,
  output logic [ID_W-1:0]          wr_id,
  output logic                     allow
);
  localparam int unsigned SLOT_W = ADDR_W - ID_W;

  logic [ADDR_W-1:0] offs;
  logic [SLOT_W-1:0] slot;
  logic              in_rng;

  always_comb begin
    in_rng = (wr_addr >= ADDR_W'(BASE_ADDR));
    offs   = wr_addr - ADDR_W'(BASE_ADDR);
    slot   = offs[ADDR_W-1:ID_W];
    wr_id  = offs[ID_W-1:0];
    win    = WIN_NONE;
    if (in_rng) begin
      case (slot)
        SLOT_W'(0): win = WIN_BAD;
        SLOT_W'(1): win = LEGACY ? WIN_BAD : WIN_CLR;
        SLOT_W'(2): win = LEGACY ? WIN_BAD : WIN_SET;
        default:    win = WIN_NONE;
      endcase
    end
    // Non-secure writes reach only interrupts marked group 1 for the writer
    allow = !HAS_SEC || wr_secure || grp1[{wr_cpu, wr_id}];
  end
endmodule

// File: rtl/sgi_trk_pick.sv
module sgi_trk_pick #(
  parameter int unsigned SRC_W = 8,
  parameter int unsigned IDX_W = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] bm,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  // Scan from the top so the lowest set bit is the last one written
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (bm[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgi_trk_cell.sv
module sgi_trk_cell #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_hit,
  input  logic             clr_hit,
  input  logic             ack_hit,
  input  logic [SRC_W-1:0] data,
  output logic [SRC_W-1:0] bitmap,
  output logic             pending
);
  logic [SRC_W-1:0] low_bit, after_ack, after_clr, bm_d;
  logic             pend_d, upd;

  // Next state: acknowledge removal, then clear, then set
  always_comb begin
    low_bit   = bitmap & (~bitmap + SRC_W'(1));
    after_ack = ack_hit ? (bitmap & ~low_bit) : bitmap;
    after_clr = clr_hit ? (after_ack & ~data) : after_ack;
    bm_d      = set_hit ? (after_clr | data) : after_clr;
    upd       = set_hit | clr_hit | ack_hit;
    if (set_hit)
      pend_d = 1'b1;
    else if (bm_d == '0)
      pend_d = 1'b0;
    else
      pend_d = pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitmap  <= '0;
      pending <= 1'b0;
    end else if (upd) begin
      bitmap  <= bm_d;
      pending <= pend_d;
    end
  end

  // R2: a non-empty bitmap is always pending
  a_r2_nonempty_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (bitmap != '0) |-> pending);

  // R1: a set write leaves the entry pending
  a_r1_set_pends: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> pending);

  // R5: retiring the last source drops pending
  a_r5_last_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !set_hit && !clr_hit && ($countones(bitmap) <= 1)) |=> !pending);

  // R6: set and clear windows never hit one entry together
  a_r6_excl_windows: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_hit, clr_hit}));
endmodule

// File: rtl/sgi_src_tracker.sv
module sgi_src_tracker
  import sgi_trk_pkg::*;
#(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_SGI   = 16,
  parameter int unsigned SRC_W     = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [11:0] BASE_ADDR = 12'hF00,
  parameter bit          HAS_SEC   = 1'b1,
  parameter bit          LEGACY    = 1'b0,
  parameter int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int unsigned ID_W      = $clog2(NUM_SGI),
  parameter int unsigned SRCIX_W   = $clog2(SRC_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [SRC_W-1:0]           wr_data,
  input  logic [CPU_W-1:0]           wr_cpu,
  input  logic                       wr_secure,
  input  logic [NUM_CPU*NUM_SGI-1:0] grp1,
  input  logic                       ack_en,
  input  logic [CPU_W-1:0]           ack_cpu,
  input  logic [ID_W-1:0]            ack_id,
  output logic [SRCIX_W-1:0]         ack_src,
  output logic                       ack_valid,
  output logic [NUM_CPU*NUM_SGI-1:0] pend,
  output logic                       wr_bad
);
  localparam int unsigned ENTRIES = NUM_CPU * NUM_SGI;

  // Reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  win_e            win;
  logic [ID_W-1:0] wr_id;
  logic            allow;

  sgi_trk_decode #(
    .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .HAS_SEC(HAS_SEC), .LEGACY(LEGACY), .CPU_W(CPU_W), .ID_W(ID_W)
  ) u_decode (
    .wr_addr(wr_addr), .wr_cpu(wr_cpu), .wr_secure(wr_secure), .grp1(grp1),
    .win(win), .wr_id(wr_id), .allow(allow)
  );

  logic set_win, clr_win;
  assign set_win = wr_en && allow && (win == WIN_SET);
  assign clr_win = wr_en && allow && (win == WIN_CLR);

  logic [SRC_W-1:0] bm_all [ENTRIES];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
      localparam int unsigned FLAT = c * NUM_SGI + s;
      logic wr_sel, ack_sel;
      assign wr_sel  = (wr_cpu == CPU_W'(c)) && (wr_id == ID_W'(s));
      assign ack_sel = ack_en && (ack_cpu == CPU_W'(c)) && (ack_id == ID_W'(s));
      sgi_trk_cell #(.SRC_W(SRC_W)) u_cell (
        .clk(clk), .rst_n(rst_ns),
        .set_hit(set_win && wr_sel), .clr_hit(clr_win && wr_sel),
        .ack_hit(ack_sel), .data(wr_data),
        .bitmap(bm_all[FLAT]), .pending(pend[FLAT])
      );
    end
  end

  // Acknowledge lookup
  logic [SRC_W-1:0]   ack_bm;
  logic [SRCIX_W-1:0] pick_idx;
  logic               pick_found;

  assign ack_bm = bm_all[{ack_cpu, ack_id}];

  sgi_trk_pick #(.SRC_W(SRC_W), .IDX_W(SRCIX_W)) u_pick (
    .bm(ack_bm), .idx(pick_idx), .found(pick_found)
  );

  assign ack_valid = ack_en && pick_found;
  assign ack_src   = ack_valid ? pick_idx : '0;

  // Bad-access report, one cycle after the write
  logic bad_d;
  always_comb bad_d = wr_en && (win == WIN_BAD);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) wr_bad <= 1'b0;
    else         wr_bad <= bad_d;
  end

  // R7: a write to the reserved range is reported next cycle
  a_r7_reserved_bad: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && (wr_addr >= ADDR_W'(BASE_ADDR)) &&
     (wr_addr < ADDR_W'(BASE_ADDR) + ADDR_W'(NUM_SGI))) |=> wr_bad);

  // R8: in legacy form both windows report a bad access
  a_r8_legacy_bad: assert property (@(posedge clk) disable iff (!rst_ns)
    (LEGACY && wr_en && (wr_addr >= ADDR_W'(BASE_ADDR) + ADDR_W'(NUM_SGI)) &&
     (wr_addr < ADDR_W'(BASE_ADDR) + ADDR_W'(3 * NUM_SGI))) |=> wr_bad);

  // R3: a filtered write leaves every pending bit unchanged
  a_r3_filtered_write: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && !allow && !ack_en && (win inside {WIN_SET, WIN_CLR})) |=> $stable(pend));

  // R4: the reported source is present in the acknowledged bitmap
  a_r4_src_present: assert property (@(posedge clk) disable iff (!rst_ns)
    ack_valid |-> ack_bm[ack_src]);

  // R4: a valid acknowledge with no set write removes the reported source
  a_r4_src_removed: assert property (@(posedge clk) disable iff (!rst_ns)
    (ack_valid && !set_win) |=> (bm_all[{$past(ack_cpu), $past(ack_id)}][$past(ack_src)] == 1'b0));
endmodule

// File: tb/test_sgi_src_tracker.sv
module test_sgi_src_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  wr_cpu = '0;
  logic        wr_secure = 1'b0;
  logic [63:0] grp1 = '0;
  logic        ack_en = 1'b0;
  logic [1:0]  ack_cpu = '0;
  logic [3:0]  ack_id = '0;
  logic [2:0]  ack_src, lg_ack_src;
  logic        ack_valid, lg_ack_valid;
  logic [63:0] pend, lg_pend;
  logic        wr_bad, lg_wr_bad;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_vec = '0;
  logic [2:0]  got_src;
  logic        got_val;

  always #4 clk = ~clk;  // 125 MHz

  sgi_src_tracker i_sgi_src_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_cpu(wr_cpu), .wr_secure(wr_secure), .grp1(grp1), .ack_en(ack_en),
    .ack_cpu(ack_cpu), .ack_id(ack_id), .ack_src(ack_src), .ack_valid(ack_valid),
    .pend(pend), .wr_bad(wr_bad)
  );

  sgi_src_tracker #(.LEGACY(1'b1)) i_sgi_src_tracker_legacy (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_cpu(wr_cpu), .wr_secure(wr_secure), .grp1(grp1), .ack_en(ack_en),
    .ack_cpu(ack_cpu), .ack_id(ack_id), .ack_src(lg_ack_src), .ack_valid(lg_ack_valid),
    .pend(lg_pend), .wr_bad(lg_wr_bad)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // op: 0 set window, 1 clear window, 2 reserved range, 3 acknowledge
  task automatic do_op(input logic [1:0] op, input logic [1:0] cpu, input logic sec,
                       input logic [3:0] id, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b0; ack_en = 1'b0;
    wr_cpu = cpu; wr_secure = sec; wr_data = data; ack_cpu = cpu; ack_id = id;
    case (op)
      2'd0: begin wr_en = 1'b1; wr_addr = 12'hF20 + 12'(id); end
      2'd1: begin wr_en = 1'b1; wr_addr = 12'hF10 + 12'(id); end
      2'd2: begin wr_en = 1'b1; wr_addr = 12'hF00 + 12'(id); end
      default: ack_en = 1'b1;
    endcase
    #1;
    got_src = ack_src;
    got_val = ack_valid;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ack_en = 1'b0;
  endtask

  // {op[2], cpu[2], sec, id[4], data[8], exp_pend, flag}
  // flag = expected wr_bad for writes, expected ack_valid for acknowledges;
  // for acknowledges data[2:0] is the expected source index
  localparam int NV = 16;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b1, 4'd2,  8'h05, 1'b1, 1'b0},  // R1 secure set
    {2'd0, 2'd0, 1'b0, 4'd2,  8'h10, 1'b1, 1'b0},  // R3 non-secure, group 1 passes
    {2'd1, 2'd0, 1'b1, 4'd2,  8'h01, 1'b1, 1'b0},  // R2 partial clear
    {2'd3, 2'd0, 1'b0, 4'd2,  8'h02, 1'b1, 1'b1},  // R4 lowest source 2
    {2'd3, 2'd0, 1'b0, 4'd2,  8'h04, 1'b0, 1'b1},  // R5 last source 4
    {2'd3, 2'd0, 1'b0, 4'd2,  8'h00, 1'b0, 1'b0},  // R5 empty acknowledge
    {2'd0, 2'd2, 1'b0, 4'd7,  8'h80, 1'b0, 1'b0},  // R3 group 0 set dropped
    {2'd0, 2'd1, 1'b0, 4'd3,  8'h02, 1'b1, 1'b0},  // R3 group 1 set
    {2'd1, 2'd1, 1'b0, 4'd3,  8'h02, 1'b0, 1'b0},  // R2 clear empties
    {2'd0, 2'd3, 1'b1, 4'd15, 8'h00, 1'b1, 1'b0},  // R1 zero data still pends
    {2'd3, 2'd3, 1'b0, 4'd15, 8'h00, 1'b0, 1'b0},  // R5 empty ack clears pend
    {2'd2, 2'd0, 1'b1, 4'd4,  8'hFF, 1'b0, 1'b1},  // R7 reserved range
    {2'd0, 2'd2, 1'b1, 4'd0,  8'hC0, 1'b1, 1'b0},  // R1 set two sources
    {2'd1, 2'd2, 1'b0, 4'd0,  8'h40, 1'b1, 1'b0},  // R3 group 0 clear dropped
    {2'd1, 2'd2, 1'b1, 4'd0,  8'h40, 1'b1, 1'b0},  // R2 secure clear
    {2'd3, 2'd2, 1'b0, 4'd0,  8'h07, 1'b0, 1'b1}   // R4 source 7 retires
  };

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // group 1: all interrupts of CPU 0, interrupt 3 of CPU 1
    grp1 = 64'h0000_0000_0008_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R9 reset pend", pend, '0);
    check("R9 reset bad", {63'b0, wr_bad}, 64'b0);

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      int          idx;
      e   = VEC[v];
      idx = int'(e[16:15]) * 16 + int'(e[13:10]);
      do_op(e[18:17], e[16:15], e[14], e[13:10], e[9:2]);
      exp_vec[idx] = e[1];
      check($sformatf("R10 vector %0d pend", v), pend, exp_vec);
      if (e[18:17] == 2'd3) begin
        check($sformatf("R4 vector %0d valid", v), {63'b0, got_val}, {63'b0, e[0]});
        check($sformatf("R4 vector %0d src", v), {61'b0, got_src},
              {61'b0, (e[0] ? e[4:2] : 3'd0)});
      end else begin
        check($sformatf("R7 vector %0d bad", v), {63'b0, wr_bad}, {63'b0, e[0]});
      end
    end

    // R7: the report lasts one cycle only
    @(negedge clk);
    check("R7 bad one cycle", {63'b0, wr_bad}, 64'b0);

    // R6: set and acknowledge together on CPU 1, interrupt 9
    do_op(2'd0, 2'd1, 1'b1, 4'd9, 8'h03);
    exp_vec[25] = 1'b1;
    check("R6 preload pend", pend, exp_vec);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'hF29; wr_data = 8'h01; wr_cpu = 2'd1; wr_secure = 1'b1;
    ack_en = 1'b1; ack_cpu = 2'd1; ack_id = 4'd9;
    #1;
    check("R6 same-cycle src", {60'b0, ack_valid, ack_src}, {60'b0, 1'b1, 3'd0});
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ack_en = 1'b0;
    check("R6 pend kept", pend, exp_vec);
    do_op(2'd3, 2'd1, 1'b0, 4'd9, 8'h00);
    check("R6 source 0 restored", {60'b0, got_val, got_src}, {60'b0, 1'b1, 3'd0});
    do_op(2'd3, 2'd1, 1'b0, 4'd9, 8'h00);
    check("R6 source 1 kept", {60'b0, got_val, got_src}, {60'b0, 1'b1, 3'd1});
    exp_vec[25] = 1'b0;
    check("R5 pend after last", pend, exp_vec);
    do_op(2'd3, 2'd1, 1'b0, 4'd9, 8'h00);
    check("R6 bitmap empty", {60'b0, got_val, got_src}, 64'b0);

    // R8: legacy form rejects both windows
    check("R8 legacy untouched", lg_pend, '0);
    do_op(2'd0, 2'd0, 1'b1, 4'd1, 8'h01);
    exp_vec[1] = 1'b1;
    check("R8 legacy set bad", {63'b0, lg_wr_bad}, 64'b1);
    check("R8 legacy no pend", lg_pend, '0);
    do_op(2'd1, 2'd0, 1'b1, 4'd1, 8'h01);
    exp_vec[1] = 1'b0;
    check("R8 legacy clear bad", {63'b0, lg_wr_bad}, 64'b1);
    check("R2 main clear", pend, exp_vec);

    // R9: reset in the middle of a run
    do_op(2'd0, 2'd3, 1'b1, 4'd6, 8'h21);
    exp_vec[54] = 1'b1;
    check("R1 before reset", pend, exp_vec);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid reset pend", pend, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_op(2'd3, 2'd3, 1'b0, 4'd6, 8'h00);
    check("R9 bitmap cleared", {60'b0, got_val, got_src}, 64'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule